// File: doc/BRIEF.md
# External Bus Dynamic Sizing Controller

This block sits between an internal transfer requester and an asynchronous external bus. An internal master asks for a byte, word or long-word read or write. The controller turns that request into as many external bus cycles as the responding device needs.

For each external cycle the controller drives:
- the address,
- a size code giving the bytes still outstanding,
- a function code,
- the read/write line,
- an address strobe and a data strobe, both active low.

It then holds the cycle open until the device answers with a two-bit data-size acknowledge. That code both ends the cycle and says how wide the device port is. The controller then advances the address and the remaining byte count by the number of bytes the port took. It repeats until nothing is left, and finally pulses a ready signal for the internal master.

A mode input selects fully expanded operation, with a 16-bit data bus. With the mode input low, the bus is partially expanded: only the upper 8-bit lane exists, and every acknowledge is handled as an 8-bit port. Only 20 address bits come from inside the block. The top four external address bits copy address bit 19.

Top module: `busSizer`

## Requirements
- R1: After reset, `asN` and `dsN` are high, `reqReady` is low and `busDataOe` is low.
- R2: `busAddr[19:0]` starts at the request address and advances by the bytes accepted in each cycle. `busAddr[23:20]` always equal `busAddr[19]`.
- R3: During each cycle, `busSiz` encodes the outstanding byte count: 4 is 00, 3 is 11, 2 is 10 and 1 is 01. `busRw` is 1 for a read and 0 for a write, and `busFc` carries `reqFc`. All of these are stable while the strobes are asserted.
- R4: A request is accepted at a clock edge where the block is idle and `reqValid` is high. Request size 0 means a byte, 1 a word, and 2 or 3 a long word. The first address is driven one clock before the strobes. `asN` and `dsN` are asserted low together and stay low until an acknowledge arrives.
- R5: The acknowledge `ackN` is sampled on the clock edge. 11 means wait, with no limit on the number of clocks. 10 means an 8-bit port. 01 or 00 means a 16-bit port.
- R6: An 8-bit port takes one byte per cycle on `busDataIn[15:8]` / `busDataOut[15:8]`, so a transfer of n bytes takes n cycles.
- R7: A 16-bit port takes two bytes, on the upper lane then the lower lane, when the address is even and two or more bytes remain. It takes one byte on the lower lane at an odd address, and one byte on the upper lane at an even address when one byte remains.
- R8: With `fullMode` low, every acknowledge other than 11 is handled as an 8-bit port.
- R9: Read data is returned big-endian and right-justified in `rdData`: the first byte fetched is the most significant byte of the transfer. `rdData` is valid while `reqReady` is high.
- R10: On a write, the upper lane carries the next byte. The lower lane carries the byte after it at an even address with two or more bytes remaining, and otherwise repeats the next byte. `busDataOe` is high only while a write cycle has its strobes asserted.
- R11: Both strobes stay high for at least one clock between cycles. `reqReady` is a single-clock pulse after the last cycle of the transfer, and it occurs while the strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fullMode | input | 1 | 1: 16-bit data bus; 0: 8-bit data bus on upper lane |
| reqValid | input | 1 | Internal transfer request |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 2 | 0 byte, 1 word, 2/3 long word |
| reqAddr | input | 20 | Internal start address |
| reqFc | input | 3 | Function code for the transfer |
| reqWdata | input | 32 | Write data, right-justified |
| reqReady | output | 1 | One-clock completion pulse |
| rdData | output | 32 | Read data, right-justified |
| busAddr | output | 24 | External address |
| busSiz | output | 2 | Outstanding-size code |
| busFc | output | 3 | External function code |
| busRw | output | 1 | 1 read, 0 write |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| busDataOut | output | 16 | Write data lanes |
| busDataOe | output | 1 | Write lanes enable |
| busDataIn | input | 16 | Read data lanes |
| ackN | input | 2 | Data-size acknowledge |

## Verification
The bench uses the default 20-bit internal and 24-bit external address widths. It sweeps every request size against all four low address offsets, with both port widths and both bus modes. Each combination runs as a read and as a write, with zero and two wait clocks. The start addresses are placed both with bit 19 set and with bit 19 clear, so the mirrored top bits toggle. This sweep covers every misaligned split, the three-byte size code, and partial-mode demotion of a 16-bit acknowledge. Each bus cycle's address, size code and lanes are checked against an arithmetic model of the bytes taken per cycle.

// File: rtl/busSizerPkg.sv
package busSizerPkg;
  localparam int LANE_W = 8;
  localparam int BUS_W  = 2 * LANE_W;
  localparam int XFER_W = 4 * LANE_W;

  localparam logic [1:0] ACK_WAIT  = 2'b11;
  localparam logic [1:0] ACK_NARROW = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_GAP
  } seqState;

  typedef struct packed {
    logic load;
    logic advance;
    logic strobing;
  } ctrlStrobes;
endpackage

// File: rtl/busSizerCtrl.sv
module busSizerCtrl
  import busSizerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] ackN,
  input  logic       remEmpty,
  output ctrlStrobes ctrl,
  output logic       asN,
  output logic       dsN,
  output logic       reqReady
);
  seqState state, stateNext;
  logic    ackSeen;

  assign ackSeen = (ackN != ACK_WAIT);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_SETUP;
      ST_SETUP:  stateNext = ST_STROBE;
      ST_STROBE: if (ackSeen) stateNext = ST_GAP;
      ST_GAP:    stateNext = remEmpty ? ST_IDLE : ST_STROBE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl.load     = (state == ST_IDLE) && reqValid;
    ctrl.advance  = (state == ST_STROBE) && ackSeen;
    ctrl.strobing = (state == ST_STROBE);
  end

  assign asN      = (state != ST_STROBE);
  assign dsN      = (state != ST_STROBE);
  assign reqReady = (state == ST_GAP) && remEmpty;
endmodule

// File: rtl/busSizerDatapath.sv
module busSizerDatapath
  import busSizerPkg::*;
#(
  parameter int INT_ADDR_W = 20,
  parameter int EXT_ADDR_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes            ctrl,
  input  logic                  fullMode,
  input  logic                  reqWrite,
  input  logic [1:0]            reqSize,
  input  logic [INT_ADDR_W-1:0] reqAddr,
  input  logic [2:0]            reqFc,
  input  logic [XFER_W-1:0]     reqWdata,
  input  logic [1:0]            ackN,
  input  logic [BUS_W-1:0]      busDataIn,
  output logic [EXT_ADDR_W-1:0] busAddr,
  output logic [1:0]            busSiz,
  output logic [2:0]            busFc,
  output logic                  busRw,
  output logic [BUS_W-1:0]      busDataOut,
  output logic                  busDataOe,
  output logic [XFER_W-1:0]     rdData,
  output logic                  remEmpty
);
  localparam int MIRROR_W = EXT_ADDR_W - INT_ADDR_W;

  logic [INT_ADDR_W-1:0] addrQ;
  logic [2:0]            remQ;
  logic [XFER_W-1:0]     wrBytes;
  logic [XFER_W-1:0]     rdAcc;
  logic                  writeQ;
  logic [2:0]            fcQ;

  logic [2:0]            reqBytes;
  logic [XFER_W-1:0]     wrAligned;
  logic                  widePort;
  logic                  takeTwo;
  logic [2:0]            take;
  logic [LANE_W-1:0]     byteFirst;
  logic [LANE_W-1:0]     byteSecond;

  always_comb begin
    case (reqSize)
      2'd0:    reqBytes = 3'd1;
      2'd1:    reqBytes = 3'd2;
      default: reqBytes = 3'd4;
    endcase
    case (reqSize)
      2'd0:    wrAligned = {reqWdata[LANE_W-1:0], {(XFER_W-LANE_W){1'b0}}};
      2'd1:    wrAligned = {reqWdata[BUS_W-1:0], {(XFER_W-BUS_W){1'b0}}};
      default: wrAligned = reqWdata;
    endcase
  end

  // Port width is decided per cycle from the acknowledge and the bus mode.
  assign widePort = fullMode && (ackN != ACK_NARROW) && (ackN != ACK_WAIT);
  assign takeTwo  = widePort && !addrQ[0] && (remQ >= 3'd2);
  assign take     = takeTwo ? 3'd2 : 3'd1;

  always_comb begin
    if (widePort && addrQ[0]) byteFirst = busDataIn[LANE_W-1:0];
    else                      byteFirst = busDataIn[BUS_W-1:LANE_W];
    byteSecond = busDataIn[LANE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      remQ    <= '0;
      wrBytes <= '0;
      rdAcc   <= '0;
      writeQ  <= 1'b0;
      fcQ     <= '0;
    end else if (ctrl.load) begin
      addrQ   <= reqAddr;
      remQ    <= reqBytes;
      wrBytes <= wrAligned;
      rdAcc   <= '0;
      writeQ  <= reqWrite;
      fcQ     <= reqFc;
    end else if (ctrl.advance) begin
      addrQ <= addrQ + INT_ADDR_W'(take);
      remQ  <= remQ - take;
      if (takeTwo) begin
        wrBytes <= {wrBytes[XFER_W-BUS_W-1:0], {BUS_W{1'b0}}};
        rdAcc   <= {rdAcc[XFER_W-BUS_W-1:0], byteFirst, byteSecond};
      end else begin
        wrBytes <= {wrBytes[XFER_W-LANE_W-1:0], {LANE_W{1'b0}}};
        rdAcc   <= {rdAcc[XFER_W-LANE_W-1:0], byteFirst};
      end
    end
  end

  generate
    if (MIRROR_W > 0) begin : g_mirror
      assign busAddr = {{MIRROR_W{addrQ[INT_ADDR_W-1]}}, addrQ};
    end else begin : g_flat
      assign busAddr = addrQ[EXT_ADDR_W-1:0];
    end
  endgenerate

  assign busSiz   = remQ[1:0];
  assign busFc    = fcQ;
  assign busRw    = !writeQ;
  assign remEmpty = (remQ == 3'd0);
  assign rdData   = rdAcc;

  always_comb begin
    busDataOut[BUS_W-1:LANE_W] = wrBytes[XFER_W-1 -: LANE_W];
    if (!addrQ[0] && remQ >= 3'd2) busDataOut[LANE_W-1:0] = wrBytes[XFER_W-LANE_W-1 -: LANE_W];
    else                           busDataOut[LANE_W-1:0] = wrBytes[XFER_W-1 -: LANE_W];
  end

  assign busDataOe = ctrl.strobing && writeQ;
endmodule

// File: rtl/busSizer.sv
module busSizer
  import busSizerPkg::*;
#(
  parameter int INT_ADDR_W = 20,
  parameter int EXT_ADDR_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fullMode,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [1:0]            reqSize,
  input  logic [INT_ADDR_W-1:0] reqAddr,
  input  logic [2:0]            reqFc,
  input  logic [31:0]           reqWdata,
  output logic                  reqReady,
  output logic [31:0]           rdData,
  output logic [EXT_ADDR_W-1:0] busAddr,
  output logic [1:0]            busSiz,
  output logic [2:0]            busFc,
  output logic                  busRw,
  output logic                  asN,
  output logic                  dsN,
  output logic [15:0]           busDataOut,
  output logic                  busDataOe,
  input  logic [15:0]           busDataIn,
  input  logic [1:0]            ackN
);
  ctrlStrobes ctrl;
  logic       remEmpty;

  busSizerCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ackN     (ackN),
    .remEmpty (remEmpty),
    .ctrl     (ctrl),
    .asN      (asN),
    .dsN      (dsN),
    .reqReady (reqReady)
  );

  busSizerDatapath #(
    .INT_ADDR_W (INT_ADDR_W),
    .EXT_ADDR_W (EXT_ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .fullMode   (fullMode),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqAddr    (reqAddr),
    .reqFc      (reqFc),
    .reqWdata   (reqWdata),
    .ackN       (ackN),
    .busDataIn  (busDataIn),
    .busAddr    (busAddr),
    .busSiz     (busSiz),
    .busFc      (busFc),
    .busRw      (busRw),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .rdData     (rdData),
    .remEmpty   (remEmpty)
  );
endmodule

// File: rtl/busSizerChk.sv
module busSizerChk #(
  parameter int INT_ADDR_W = 20,
  parameter int EXT_ADDR_W = 24
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqReady,
  input logic [EXT_ADDR_W-1:0] busAddr,
  input logic [1:0]            busSiz,
  input logic                  busRw,
  input logic                  asN,
  input logic                  dsN,
  input logic                  busDataOe,
  input logic [1:0]            ackN
);
  AST_ADDR_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[EXT_ADDR_W-1:INT_ADDR_W] == {(EXT_ADDR_W-INT_ADDR_W){busAddr[INT_ADDR_W-1]}})); // R2

  AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && $past(!asN)) |-> ($stable(busAddr) && $stable(busSiz) && $stable(busRw))); // R3

  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    (asN == dsN)); // R4

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && ackN == 2'b11) |=> !asN); // R5

  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (!busRw && !asN)); // R10

  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && ackN != 2'b11) |=> (asN && dsN)); // R11

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady); // R11

  AST_READY_STROBES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (asN && dsN)); // R11
endmodule

bind busSizer busSizerChk #(
  .INT_ADDR_W (INT_ADDR_W),
  .EXT_ADDR_W (EXT_ADDR_W)
) u_chk (.*);

// File: tb/busSizer_tb.sv
module busSizer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fullMode = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [19:0] reqAddr = '0;
  logic [2:0]  reqFc = 3'd0;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic [31:0] rdData;
  logic [23:0] busAddr;
  logic [1:0]  busSiz;
  logic [2:0]  busFc;
  logic        busRw;
  logic        asN;
  logic        dsN;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn = '0;
  logic [1:0]  ackN = 2'b11;

  busSizer u_dut (
    .clk(clk), .rstN(rstN), .fullMode(fullMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .reqFc(reqFc),
    .reqWdata(reqWdata), .reqReady(reqReady), .rdData(rdData),
    .busAddr(busAddr), .busSiz(busSiz), .busFc(busFc), .busRw(busRw),
    .asN(asN), .dsN(dsN), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .ackN(ackN)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [7:0] mem [256];

  // device-side model state
  bit          portWide = 1'b0;
  int          waitSet = 0;
  int          waitCnt = 0;
  bit          fresh = 1'b1;
  logic [19:0] devAddr = '0;
  int          devRem = 0;
  bit          devWrite = 1'b0;
  int          busCycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] extAddr(input logic [19:0] a);
    return {{4{a[19]}}, a};
  endfunction

  function automatic logic [1:0] sizCode(input int rem);
    return 2'(rem % 4);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Device model: answers each strobed cycle after waitSet clocks.
  always @(negedge clk) begin
    if (!rstN) begin
      ackN = 2'b11;
      fresh = 1'b1;
    end else if (asN) begin
      ackN = 2'b11;
      fresh = 1'b1;
    end else if (ackN == 2'b11) begin
      if (fresh) begin
        fresh = 1'b0;
        waitCnt = 0;
        busCycles++;
        check(busAddr == extAddr(devAddr), "R2", "cycle address", 32'(busAddr), 32'(extAddr(devAddr)));
        check(busSiz == sizCode(devRem) && busRw == !devWrite && busFc == reqFc,
              "R3", "size/rw/fc", {27'd0, busFc, busSiz}, {27'd0, reqFc, sizCode(devRem)});
        if (devWrite)
          check(busDataOe == 1'b1, "R10", "write lane enable", 32'(busDataOe), 32'd1);
      end
      if (waitCnt == waitSet) begin
        bit wide;
        int take;
        wide = fullMode && portWide;
        take = (wide && !devAddr[0] && devRem >= 2) ? 2 : 1;
        ackN = portWide ? 2'b01 : 2'b10;
        if (devWrite) begin
          if (wide && devAddr[0]) mem[devAddr[7:0]] = busDataOut[7:0];
          else                    mem[devAddr[7:0]] = busDataOut[15:8];
          if (take == 2) mem[8'(devAddr[7:0] + 8'd1)] = busDataOut[7:0];
        end else if (wide) begin
          busDataIn = {mem[{devAddr[7:1], 1'b0}], mem[{devAddr[7:1], 1'b1}]};
        end else begin
          busDataIn = {mem[devAddr[7:0]], 8'h5A};
        end
        devAddr = devAddr + 20'(take);
        devRem  = devRem - take;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic runXfer(input bit wr, input int sizeSel, input logic [19:0] addr,
                         input logic [31:0] wdata, input logic [2:0] fc);
    int n;
    logic [31:0] expRead;
    int expCycles;
    int guard;
    bit wide;
    n = (sizeSel == 0) ? 1 : (sizeSel == 1) ? 2 : 4;
    wide = fullMode && portWide;
    expRead = '0;
    for (int i = 0; i < n; i++) expRead = (expRead << 8) | 32'(mem[8'(addr[7:0] + 8'(i))]);
    expCycles = wide ? ((int'(addr[0]) + n + 1) / 2) : n;

    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqSize  = 2'(sizeSel);
    reqAddr  = addr;
    reqWdata = wdata;
    reqFc    = fc;
    devAddr  = addr;
    devRem   = n;
    devWrite = wr;
    busCycles = 0;
    @(negedge clk);
    reqValid = 1'b0;
    check(asN == 1'b1 && busAddr == extAddr(addr), "R4", "address setup before strobe",
          {asN, 7'd0, busAddr}, {1'b1, 7'd0, extAddr(addr)});
    @(negedge clk);
    check(asN == 1'b0 && dsN == 1'b0, "R4", "strobes asserted", {30'd0, asN, dsN}, 32'd0);
    guard = 0;
    while (!reqReady && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(reqReady == 1'b1, "R11", "ready reached", 32'(reqReady), 32'd1);
    check(asN && dsN, "R11", "strobes negated at ready", {30'd0, asN, dsN}, 32'd3);
    if (!fullMode)
      check(busCycles == n, "R8", "partial mode byte cycles", 32'(busCycles), 32'(n));
    else if (portWide)
      check(busCycles == expCycles, "R7", "16-bit port cycle count", 32'(busCycles), 32'(expCycles));
    else
      check(busCycles == expCycles, "R6", "8-bit port cycle count", 32'(busCycles), 32'(expCycles));
    if (wr) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] e;
        logic [7:0] a;
        e = 8'(wdata >> (8 * (n - 1 - i)));
        a = mem[8'(addr[7:0] + 8'(i))];
        check(a == e, "R10", "written byte", 32'(a), 32'(e));
      end
    end else begin
      check(rdData == expRead, "R9", "read data", rdData, expRead);
    end
    @(negedge clk);
    check(reqReady == 1'b0, "R11", "ready single pulse", 32'(reqReady), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    check(asN && dsN && !reqReady && !busDataOe, "R1", "reset outputs",
          {28'd0, asN, dsN, reqReady, busDataOe}, 32'hC);
    rstN = 1'b1;
    @(negedge clk);
    check(asN && dsN && !reqReady && !busDataOe, "R1", "idle after reset",
          {28'd0, asN, dsN, reqReady, busDataOe}, 32'hC);

    // R5: long wait holds the strobes, then a narrow ack ends the cycle.
    fullMode = 1'b1;
    portWide = 1'b0;
    waitSet  = 9;
    runXfer(1'b0, 0, 20'h800F1, 32'h0, 3'd5);

    for (int md = 0; md < 2; md++)
      for (int pw = 0; pw < 2; pw++)
        for (int ws = 0; ws < 2; ws++)
          for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off++)
              for (int wr = 0; wr < 2; wr++) begin
                logic [19:0] base;
                fullMode = md[0];
                portWide = pw[0];
                waitSet  = ws * 2;
                base = (off[0] ^ pw[0]) ? 20'h800F0 : 20'h000F0;
                runXfer(wr[0], sz, base + 20'(off),
                        32'hA1B2C3D4 ^ (32'(sz * 16 + off) << 4) ^ 32'(md * 8 + pw),
                        3'(sz + off));
              end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule